// File: doc/BRIEF.md
# SPI flash frame sequencer

This block is the host side of a single-lane serial flash link. Software places bytes in a transmit FIFO, programs a frame length and a command length, and then launches the frame. The sequencer drops chip select and shifts bytes out MSB first. For the leading command bytes it discards whatever the flash returns. For the rest of the frame it clocks out 0xFF filler and captures each returned byte into a receive FIFO. A command length of zero turns every byte of the frame into a full-duplex exchange: each one is taken from the transmit FIFO and each returns a byte.

Both FIFOs can be accessed one byte at a time. When a control flag is set they can also be accessed four bytes at a time through a word port. A status register, an interrupt enable mask and a single level interrupt let software poll the block or wait on it. The serial clock is the system clock divided by twice a 4-bit rate value. A control bit chooses the clock rest level, so the link runs in SPI mode 0 or mode 3.

The register port is a simple synchronous strobe interface. Register addresses are: 0 control, 1 length low half, 2 length high half, 3 command length and launch, 4 status, 5 interrupt enable, 6 byte data, 7 word data. Control fields are: [3:0] rate, [4] clock rests high, [5] word access enable.

Top module: `sfs_top`

## Requirements
- R1: A write to address 3 while idle with a nonzero 32-bit length ({addr2, addr1}) drives cs_n low, produces exactly 8 rising sclk edges per byte of the length, and then returns cs_n high; after reset cs_n is high.
- R2: With a command length C (address 3, bits [8:0]) greater than zero, bytes 0..C-1 of the frame are taken from the transmit FIFO in order and shifted MSB first, and their received bytes are not stored.
- R3: With C greater than zero, bytes C..length-1 go out as 0xFF, and each received byte (sampled MSB first on the rising sclk edge) is appended to the receive FIFO in order.
- R4: With C equal to zero, every byte of the frame is taken from the transmit FIFO and every received byte is stored in the receive FIFO.
- R5: sclk stays high and low for R system clocks each within a byte, where R is control bits [3:0]; R = 0 behaves as R = 1.
- R6: Between frames sclk rests at the level of control bit 4 (0 = mode 0, 1 = mode 3).
- R7: When a byte must come from the transmit FIFO and the FIFO is empty, the frame pauses with cs_n low and sclk at its rest level, and it resumes when a byte is pushed.
- R8: Status (address 4) reads bit 0 tx-done, bit 1 rx-done, bit 2 receive FIFO not empty, bit 3 transmit FIFO not full, bit 4 receive FIFO empty, bit 5 transmit FIFO full, bit 7 idle, and 0 in other bits; after reset it reads 0x98.
- R9: tx-done and rx-done are set when cs_n returns high at the end of a frame, and writing 1 to a bit of status address 4 clears it.
- R10: irq is high exactly when some status bit and the same bit of the enable mask (address 5) are both 1.
- R11: With control bit 5 set, a write to address 7 pushes four bytes, low byte first, and a read pops four bytes into [7:0], [15:8], [23:16], [31:24] in FIFO order; with bit 5 clear, word writes are ignored and word reads return 0 without popping.
- R12: Each FIFO holds 16 bytes; a push to a full transmit FIFO is dropped, and a byte read (address 6) from an empty receive FIFO returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops data ports) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| irq | output | 1 | Combined level interrupt |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions rely on the host only launching a frame while the block is idle. They also rely on the command length not exceeding the frame length, so that every byte software pushes is consumed by the frame it was meant for. The stimulus meets both conditions: it waits for cs_n to rise before every launch, and it draws the random command length from zero up to the frame length. Frame lengths stay at 16 or below, so the receive FIFO never fills and the data phase never stalls. The serial responder changes miso only after a falling sclk edge.

// File: rtl/sfs_pkg.sv
// Shared types and register encodings for the serial flash frame sequencer.
package sfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_FINISH
    } sfs_state_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_TLO  = 3'd1;
    localparam logic [2:0] A_THI  = 3'd2;
    localparam logic [2:0] A_GO   = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;
    localparam logic [2:0] A_IEN  = 3'd5;
    localparam logic [2:0] A_BYTE = 3'd6;
    localparam logic [2:0] A_WORD = 3'd7;

    localparam int B_TXDONE  = 0;
    localparam int B_RXDONE  = 1;
    localparam int B_RXAVAIL = 2;
    localparam int B_TXAVAIL = 3;
    localparam int B_RXEMPTY = 4;
    localparam int B_TXFULL  = 5;
    localparam int B_READY   = 7;

endpackage

// File: rtl/sfs_fifo.sv
// Byte FIFO that accepts up to LANES bytes per push and per pop.
// Assumes: DEPTH is a power of two, and the caller never pushes more bytes
// than there are free slots or pops more than it holds.
module sfs_fifo #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int NW   = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NW-1:0]      push_n,
    input  logic [8*LANES-1:0] push_data,
    input  logic [NW-1:0]      pop_n,
    output logic [8*LANES-1:0] peek,
    output logic [CW-1:0]      level
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;

    // Storage write: lane k lands in the slot k places after the write pointer.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (32'(push_n) > k) mem[wp + AW'(k)] <= push_data[8*k +: 8];
        end
    end

    // Pointer and fill level update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_n);
            level <= level + CW'(push_n) - CW'(pop_n);
        end
    end

    // Head bytes, oldest in the lowest lane.
    for (genvar g = 0; g < LANES; g++) begin : g_peek
        assign peek[8*g +: 8] = mem[rp + AW'(g)];
    end

    // R12
    level_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    // R12
    pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= level);

endmodule

// File: rtl/sfs_clkdiv.sv
// Half-period tick generator for the serial clock.
// Assumes: the engine holds clear while it waits, so each half period starts at 0.
module sfs_clkdiv #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    logic [RATE_W-1:0] cnt;
    logic [RATE_W-1:0] lim;

    // A rate of zero is treated as one.
    assign lim  = (rate == '0) ? '0 : rate - RATE_W'(1);
    assign tick = en && !clear && (cnt == lim);

    // Count system clocks inside one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick || !en) cnt <= '0;
        else                                cnt <= cnt + RATE_W'(1);
    end

    // R5
    half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clear |-> cnt <= lim);

endmodule

// File: rtl/sfs_engine.sv
// Frame engine: chip select, serial clock, shift registers and the split of a
// frame into a command phase (receive discarded) and a data phase (receive kept).
// Assumes: start only arrives while idle; tick comes from sfs_clkdiv.
module sfs_engine
    import sfs_pkg::*;
#(
    parameter int RATE_W = 4,
    parameter int CNT_W  = 32,
    parameter int CMD_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  total,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [RATE_W-1:0] rate,
    input  logic              idle_hi,
    input  logic              tx_empty,
    input  logic [7:0]        tx_byte,
    input  logic              rx_full,
    input  logic              tick,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [7:0]        rx_byte,
    output logic              div_en,
    output logic              div_clear,
    output logic [RATE_W-1:0] rate_q,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    output logic              busy,
    output logic              done
);

    sfs_state_e       state;
    logic [CNT_W-1:0] idx, total_q;
    logic [CMD_W-1:0] cmd_q;
    logic             idle_q, keep_q;
    logic [7:0]       shreg, rxsh;
    logic [2:0]       bitc;
    logic             from_fifo, returns, can_go;

    // Phase of the byte about to start.
    assign from_fifo = (cmd_q == '0) || (idx < CNT_W'(cmd_q));
    assign returns   = (cmd_q == '0) || (idx >= CNT_W'(cmd_q));
    assign can_go    = (!from_fifo || !tx_empty) && (!returns || !rx_full);

    // Per-cycle strobes to the FIFOs and the divider.
    always_comb begin
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        div_clear = 1'b0;
        case (state)
            ST_IDLE: div_clear = 1'b1;
            ST_LOAD: begin
                div_clear = 1'b1;
                tx_pop    = can_go && from_fifo;
            end
            ST_HIGH: rx_push = tick && (bitc == 3'd7) && keep_q;
            default: ;
        endcase
    end

    // Frame sequencing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            total_q <= '0;
            cmd_q   <= '0;
            rate_q  <= '0;
            idle_q  <= 1'b0;
            keep_q  <= 1'b0;
            shreg   <= '0;
            rxsh    <= '0;
            bitc    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start && total != '0) begin
                    total_q <= total;
                    cmd_q   <= cmd;
                    rate_q  <= rate;
                    idle_q  <= idle_hi;
                    idx     <= '0;
                    state   <= ST_SETUP;
                end
                ST_SETUP: if (tick) state <= ST_LOAD;
                ST_LOAD: if (can_go) begin
                    shreg  <= from_fifo ? tx_byte : 8'hFF;
                    keep_q <= returns;
                    bitc   <= '0;
                    state  <= ST_LOW;
                end
                ST_LOW: if (tick) begin
                    rxsh  <= {rxsh[6:0], miso};
                    state <= ST_HIGH;
                end
                ST_HIGH: if (tick) begin
                    if (bitc == 3'd7) begin
                        idx   <= idx + CNT_W'(1);
                        state <= (idx + CNT_W'(1) == total_q) ? ST_FINISH : ST_LOAD;
                    end else begin
                        shreg <= {shreg[6:0], 1'b0};
                        bitc  <= bitc + 3'd1;
                        state <= ST_LOW;
                    end
                end
                ST_FINISH: if (tick) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rx_byte = rxsh;
    assign mosi    = shreg[7];
    assign cs_n    = (state == ST_IDLE);
    assign busy    = (state != ST_IDLE);
    assign div_en  = busy;
    assign sclk    = (state == ST_IDLE) ? idle_hi :
                     (state == ST_LOW)  ? 1'b0 :
                     (state == ST_HIGH) ? 1'b1 : idle_q;

    // R1
    byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> idx <= total_q);
    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);
    // R2
    cmd_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (cmd_q == '0) || (idx >= CNT_W'(cmd_q)));
    // R7
    stall_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

endmodule

// File: rtl/sfs_top.sv
// Top of the serial flash frame sequencer: register port, status and
// interrupt, two byte FIFOs, the divider and the frame engine.
// Assumes: software launches a frame only while status bit 7 is set.
module sfs_top
    import sfs_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int RATE_W     = 4,
    parameter int CMD_W      = 9,
    parameter int HALF_W     = 16,
    localparam int CNT_W     = 2 * HALF_W,
    localparam int LANES     = 4,
    localparam int DW        = 8 * LANES,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1,
    localparam int NW        = $clog2(LANES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          sclk,
    output logic          cs_n,
    output logic          mosi,
    input  logic          miso
);

    logic [RATE_W-1:0] ctrl_rate, rate_q;
    logic              ctrl_idle, ctrl_word;
    logic [HALF_W-1:0] tot_lo, tot_hi;
    logic [CMD_W-1:0]  cmd_reg;
    logic [7:0]        ien, status;
    logic              ev_txdone, ev_rxdone;
    logic [NW-1:0]     tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [DW-1:0]     tx_peek, rx_peek;
    logic [LVL_W-1:0]  tx_lvl, rx_lvl;
    logic              tx_pop, rx_push, tick, div_en, div_clear, busy, done, start;
    logic [7:0]        rx_byte;
    logic              wr_stat;

    assign start   = reg_wr && (reg_addr == A_GO);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_rate <= '0;
            ctrl_idle <= 1'b0;
            ctrl_word <= 1'b0;
            tot_lo    <= '0;
            tot_hi    <= '0;
            cmd_reg   <= '0;
            ien       <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    ctrl_rate <= reg_wdata[RATE_W-1:0];
                    ctrl_idle <= reg_wdata[RATE_W];
                    ctrl_word <= reg_wdata[RATE_W+1];
                end
                A_TLO:  tot_lo  <= reg_wdata[HALF_W-1:0];
                A_THI:  tot_hi  <= reg_wdata[HALF_W-1:0];
                A_GO:   cmd_reg <= reg_wdata[CMD_W-1:0];
                A_IEN:  ien     <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    // Completion events: set at frame end, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_txdone <= 1'b0;
            ev_rxdone <= 1'b0;
        end else begin
            ev_txdone <= done || (ev_txdone && !(wr_stat && reg_wdata[B_TXDONE]));
            ev_rxdone <= done || (ev_rxdone && !(wr_stat && reg_wdata[B_RXDONE]));
        end
    end

    // Status vector and combined interrupt.
    always_comb begin
        status            = '0;
        status[B_TXDONE]  = ev_txdone;
        status[B_RXDONE]  = ev_rxdone;
        status[B_RXAVAIL] = (rx_lvl != '0);
        status[B_TXAVAIL] = (tx_lvl != LVL_W'(FIFO_DEPTH));
        status[B_RXEMPTY] = (rx_lvl == '0);
        status[B_TXFULL]  = (tx_lvl == LVL_W'(FIFO_DEPTH));
        status[B_READY]   = !busy;
    end
    assign irq = |(status & ien);

    // FIFO access from the register port.
    always_comb begin
        tx_push_n = '0;
        rx_pop_n  = '0;
        if (reg_wr && reg_addr == A_BYTE && tx_lvl < LVL_W'(FIFO_DEPTH))
            tx_push_n = NW'(1);
        if (reg_wr && reg_addr == A_WORD && ctrl_word && tx_lvl <= LVL_W'(FIFO_DEPTH - LANES))
            tx_push_n = NW'(LANES);
        if (reg_rd && reg_addr == A_BYTE && rx_lvl != '0)
            rx_pop_n = NW'(1);
        if (reg_rd && reg_addr == A_WORD && ctrl_word && rx_lvl >= LVL_W'(LANES))
            rx_pop_n = NW'(LANES);
    end
    assign tx_pop_n  = NW'(tx_pop);
    assign rx_push_n = NW'(rx_push);

    // Read data selection.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[RATE_W+1:0] = {ctrl_word, ctrl_idle, ctrl_rate};
            A_TLO:  reg_rdata[HALF_W-1:0] = tot_lo;
            A_THI:  reg_rdata[HALF_W-1:0] = tot_hi;
            A_GO:   reg_rdata[CMD_W-1:0]  = cmd_reg;
            A_STAT: reg_rdata[7:0]        = status;
            A_IEN:  reg_rdata[7:0]        = ien;
            A_BYTE: if (rx_lvl != '0) reg_rdata[7:0] = rx_peek[7:0];
            A_WORD: if (ctrl_word && rx_lvl >= LVL_W'(LANES)) reg_rdata = rx_peek;
            default: ;
        endcase
    end

    sfs_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES)) u_txf (
        .clk(clk), .rst_n(rst_n), .push_n(tx_push_n), .push_data(reg_wdata),
        .pop_n(tx_pop_n), .peek(tx_peek), .level(tx_lvl)
    );

    sfs_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES)) u_rxf (
        .clk(clk), .rst_n(rst_n), .push_n(rx_push_n), .push_data({{(DW-8){1'b0}}, rx_byte}),
        .pop_n(rx_pop_n), .peek(rx_peek), .level(rx_lvl)
    );

    sfs_clkdiv #(.RATE_W(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(div_en), .clear(div_clear), .rate(rate_q), .tick(tick)
    );

    sfs_engine #(.RATE_W(RATE_W), .CNT_W(CNT_W), .CMD_W(CMD_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .total({tot_hi, tot_lo}),
        .cmd(reg_wdata[CMD_W-1:0]), .rate(ctrl_rate), .idle_hi(ctrl_idle),
        .tx_empty(tx_lvl == '0), .tx_byte(tx_peek[7:0]),
        .rx_full(rx_lvl == LVL_W'(FIFO_DEPTH)), .tick(tick), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte), .div_en(div_en),
        .div_clear(div_clear), .rate_q(rate_q), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .busy(busy), .done(done)
    );

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && reg_wdata[B_TXDONE] && !done |=> !status[B_TXDONE]);
    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[B_READY] |-> cs_n);

endmodule

// File: tb/sfs_top_test.sv
// Self-checking bench: a serial responder model, directed corner cases and
// seeded random frames, all compared against values computed here.
module sfs_top_test;

    localparam logic [2:0] AD_CTRL = 3'd0, AD_TLO = 3'd1, AD_THI = 3'd2, AD_GO = 3'd3;
    localparam logic [2:0] AD_STAT = 3'd4, AD_IEN = 3'd5, AD_BYTE = 3'd6, AD_WORD = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sclk, cs_n, mosi, miso;

    int errors = 0;
    int checks = 0;

    logic [7:0] tx_data [0:31];
    logic [7:0] s_resp  [0:31];
    logic [7:0] s_got   [0:31];
    logic [7:0] s_sh = '0;
    int  s_rises = 0, s_shown = 0, hi_run = 0, last_hi = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;

    sfs_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always #10 clk = ~clk;

    assign miso = s_resp[(s_shown / 8) % 32][7 - (s_shown % 8)];

    // Responder model and clock measurement, sampled away from the active edge.
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            s_rises = 0;
            s_shown = 0;
        end
        if (!cs_n && sclk && !prev_sclk) begin
            s_sh = {s_sh[6:0], mosi};
            if (s_rises % 8 == 7 && s_rises < 256) s_got[s_rises / 8] = s_sh;
            s_rises++;
        end
        if (!cs_n && !sclk && prev_sclk && s_rises > 0) s_shown = s_rises;
        if (!cs_n && sclk) hi_run++;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_ctrl(input int rate, input int mode3, input int word);
        reg_write(AD_CTRL, 32'(rate % 16) | (32'(mode3) << 4) | (32'(word) << 5));
    endtask

    task automatic push_bytes(input int n);
        for (int i = 0; i < n; i++) reg_write(AD_BYTE, {24'd0, tx_data[i]});
    endtask

    task automatic start_and_wait(input int total, input int cmd);
        reg_write(AD_TLO, 32'(total) & 32'hFFFF);
        reg_write(AD_THI, 32'(total) >> 16);
        reg_write(AD_GO, 32'(cmd));
        while (cs_n) @(negedge clk);
        while (!cs_n) @(negedge clk);
    endtask

    task automatic check_frame(input int total, input int cmd, input int rate, input int mode3);
        chk("R1 rising edges per frame", 32'(s_rises), 32'(8 * total));
        for (int i = 0; i < total; i++) begin
            if (cmd == 0)     chk("R4 byte sent from FIFO", {24'd0, s_got[i]}, {24'd0, tx_data[i]});
            else if (i < cmd) chk("R2 command byte sent", {24'd0, s_got[i]}, {24'd0, tx_data[i]});
            else              chk("R3 filler byte sent", {24'd0, s_got[i]}, 32'hFF);
        end
        if (mode3 == 0) chk("R5 high half period", 32'(last_hi), 32'(rate == 0 ? 1 : rate));
        chk("R6 rest level after frame", {31'd0, sclk}, 32'(mode3));
    endtask

    task automatic drain_rx(input int total, input int cmd);
        logic [31:0] d;
        int nret = (cmd == 0) ? total : total - cmd;
        for (int k = 0; k < nret; k++) begin
            reg_read(AD_BYTE, d);
            chk(cmd == 0 ? "R4 returned byte" : "R3 returned byte", d, {24'd0, s_resp[(cmd == 0) ? k : cmd + k]});
        end
        reg_read(AD_STAT, d);
        chk("R8 receive FIFO empty flag", {31'd0, d[4]}, 32'd1);
    endtask

    task automatic check_done();
        logic [31:0] d;
        reg_read(AD_STAT, d);
        chk("R9 done flags set", {30'd0, d[1:0]}, 32'd3);
        chk("R8 idle flag", {31'd0, d[7]}, 32'd1);
        reg_write(AD_STAT, 32'd3);
        reg_read(AD_STAT, d);
        chk("R9 done flags cleared", {30'd0, d[1:0]}, 32'd0);
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) begin
            tx_data[i] = 8'($urandom);
            s_resp[i]  = 8'($urandom);
        end
    endtask

    task automatic run_frame(input int total, input int cmd, input int rate, input int mode3);
        fill(total);
        set_ctrl(rate, mode3, 0);
        push_bytes(cmd == 0 ? total : cmd);
        start_and_wait(total, cmd);
        check_frame(total, cmd, rate, mode3);
        drain_rx(total, cmd);
        check_done();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) begin
            tx_data[i] = '0; s_resp[i] = '0; s_got[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        chk("R1 cs_n high after reset", {31'd0, cs_n}, 32'd1);
        chk("R6 rest level after reset", {31'd0, sclk}, 32'd0);
        chk("R10 irq low after reset", {31'd0, irq}, 32'd0);
        reg_read(AD_STAT, d);
        chk("R8 status after reset", d, 32'h98);

        // Byte read of an empty receive FIFO.
        reg_read(AD_BYTE, d);
        chk("R12 empty pop returns zero", d, 32'd0);
        reg_read(AD_STAT, d);
        chk("R12 still empty after pop", {31'd0, d[4]}, 32'd1);

        // Directed frame shapes.
        run_frame(1, 1, 1, 0);
        run_frame(1, 0, 2, 0);
        run_frame(10, 4, 3, 0);
        run_frame(10, 0, 1, 1);
        run_frame(10, 10, 0, 1);
        run_frame(3, 1, 4, 0);

        // R7: pause while a command byte is missing.
        fill(3);
        set_ctrl(1, 0, 0);
        push_bytes(1);
        reg_write(AD_TLO, 32'd3);
        reg_write(AD_THI, 32'd0);
        reg_write(AD_GO, 32'd3);
        repeat (80) @(negedge clk);
        chk("R7 cs_n held low while waiting", {31'd0, cs_n}, 32'd0);
        chk("R7 only first byte clocked", 32'(s_rises), 32'd8);
        chk("R7 sclk at rest while waiting", {31'd0, sclk}, 32'd0);
        reg_write(AD_BYTE, {24'd0, tx_data[1]});
        reg_write(AD_BYTE, {24'd0, tx_data[2]});
        while (!cs_n) @(negedge clk);
        check_frame(3, 3, 1, 0);
        check_done();

        // R12: seventeenth push is dropped.
        fill(17);
        set_ctrl(1, 0, 0);
        push_bytes(17);
        reg_read(AD_STAT, d);
        chk("R12 transmit full flag", {31'd0, d[5]}, 32'd1);
        chk("R8 transmit not-full flag clear", {31'd0, d[3]}, 32'd0);
        start_and_wait(16, 16);
        check_frame(16, 16, 1, 0);
        check_done();
        tx_data[0] = 8'hC3;
        push_bytes(1);
        start_and_wait(1, 1);
        chk("R12 overflow byte was dropped", {24'd0, s_got[0]}, 32'hC3);

        // R10: interrupt mask.
        reg_write(AD_IEN, 32'h01);
        chk("R10 irq on tx-done", {31'd0, irq}, 32'd1);
        reg_write(AD_STAT, 32'h01);
        chk("R10 irq off after clear", {31'd0, irq}, 32'd0);
        reg_write(AD_IEN, 32'h10);
        chk("R10 irq on receive empty", {31'd0, irq}, 32'd1);
        reg_write(AD_IEN, 32'h00);
        reg_write(AD_STAT, 32'h03);
        chk("R10 irq off with mask clear", {31'd0, irq}, 32'd0);

        // R11: word port enabled.
        fill(4);
        tx_data[0] = 8'h11; tx_data[1] = 8'h22; tx_data[2] = 8'h33; tx_data[3] = 8'h44;
        set_ctrl(2, 0, 1);
        reg_write(AD_WORD, 32'h44332211);
        start_and_wait(4, 0);
        check_frame(4, 0, 2, 0);
        reg_read(AD_WORD, d);
        chk("R11 word read order", d, {s_resp[3], s_resp[2], s_resp[1], s_resp[0]});
        reg_read(AD_STAT, d);
        chk("R11 word read popped four", {31'd0, d[4]}, 32'd1);
        reg_write(AD_STAT, 32'h03);

        // R11: word port disabled.
        set_ctrl(1, 0, 0);
        reg_write(AD_WORD, 32'hDEADBEEF);
        fill(1);
        tx_data[0] = 8'h5A;
        push_bytes(1);
        start_and_wait(1, 0);
        chk("R11 word write ignored", {24'd0, s_got[0]}, 32'h5A);
        reg_read(AD_WORD, d);
        chk("R11 word read disabled", d, 32'd0);
        reg_read(AD_BYTE, d);
        chk("R11 byte still queued", d, {24'd0, s_resp[0]});
        reg_write(AD_STAT, 32'h03);

        // Seeded random frames.
        for (int n = 0; n < 24; n++) begin
            int total = $urandom_range(1, 12);
            int cmd   = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, total);
            run_frame(total, cmd, $urandom_range(0, 4), $urandom_range(0, 1));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule